// File: doc/BRIEF.md
# Three-wire serial word memory slave

This block is the slave end of a three-wire serial memory link. A host raises chip select, toggles a serial clock and shifts commands in on a data-in line. The block answers on a data-out line, which it drives only while it has something to say. Behind the link sits a 64-word by 16-bit array held in flip-flops. A write does not finish at once: a down-counter holds the block busy for a programmable number of system clock cycles, in place of the time a real cell needs to erase and program.

The serial pins are sampled by the block's own system clock. Chip select, serial clock and data in pass through synchronizers, and a rising edge on the synchronized serial clock advances the command engine by one bit.

Every command opens with a start bit, which is the first 1 seen after chip select rises. A two-bit operation code follows, then a six-bit field sent most significant bit first. Code 10 reads from the address in the field. Code 01 writes to that address and takes sixteen data bits, D15 first. Code 00 is a control command: when the field begins with 11 it enables writes, and when it begins with 00 it disables them. The other four field bits are don't-care.

After a committed write, the next assertion of chip select shows a ready/busy flag on data out. The flag stays there until the next start bit arrives.

Top module: `mw_serial_mem`

## Requirements
- R1: Bits that are 0 and arrive after chip select rises, but before the first 1, are ignored. The first 1 is taken as the start bit, and decoding begins with the bit after it.
- R2: On a read (code 10), the rising edge that carries A0 puts a dummy 0 on data out. The next 16 rising edges then present the addressed word, D15 first.
- R3: If clocking continues after D0, the word at the next higher address follows at once, with no new command and no dummy bit. Address 63 is followed by address 0.
- R4: A write (code 01) that is accepted replaces the addressed word with the 16 data bits. The data is stored on the rising edge that carries D0.
- R5: Write enable is cleared by reset. A control command whose field begins with 11 sets it, and one whose field begins with 00 clears it. A write sent while write enable is clear leaves the array unchanged.
- R6: Data out is not driven (do_en_o low) whenever cs_i is low. It is also not driven while a command is being shifted in.
- R7: After a stored write, lowering chip select and raising it again makes data out show 0 while the program timer runs and 1 once the timer expires. The flag is removed when the next start bit is sampled.
- R8: Lowering chip select part way through a command discards that command. A write cut off before D0 leaves the array unchanged.
- R9: A write that completes while the program timer is still running is dropped, and the array is left unchanged.
- R10: After reset every word reads as 0 and data out is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; it oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in, sampled on the rising edge of sk_i |
| do_o | output | 1 | Serial data out: read data or the ready/busy flag |
| do_en_o | output | 1 | Output enable for do_o; when low, the pad is high-impedance |

## Verification
Most internal faults in this block show up on data out within one serial bit. A wrong state or bit count shifts the read stream by one position, or loses the dummy bit, on the very next word read. A fault in the address increment shows up at the first word boundary of a continued read, and the wrap is checked at address 63. Faults in write enable or in the timer gate corrupt the array without any immediate sign. The bench catches them through a read-back after each write. It also watches the ready/busy flag at the next chip select, both before and after the timer runs out.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_FIELD,
    ST_DATA,
    ST_READ,
    ST_DONE
  } mw_state_e;

  localparam logic [1:0] OPC_CTRL  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

  localparam logic [1:0] CTL_WDIS  = 2'b00;
  localparam logic [1:0] CTL_WEN   = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mw_serial_mem.sv
module mw_serial_mem
  import mw_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_en_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic cs_s, sk_s, di_s, sk_q;
  logic bit_stb;

  mw_sync #(.STAGES(SYNC_STAGES)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(cs_i), .sync_o(cs_s));
  mw_sync #(.STAGES(SYNC_STAGES)) u_sync_sk (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(sk_i), .sync_o(sk_s));
  mw_sync #(.STAGES(SYNC_STAGES)) u_sync_di (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(di_i), .sync_o(di_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sk_q <= 1'b0;
    else         sk_q <= sk_s;
  end

  assign bit_stb = cs_s & sk_s & ~sk_q;

  mw_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        opc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wr_sh_q;
  logic [DATA_W-1:0] rd_sh_q;
  logic              dout_q;
  logic              wen_q;
  logic              stat_q;
  logic              busy;
  logic              mem_we;
  logic              rd_active;
  logic [ADDR_W-1:0] field_nxt;
  logic [ADDR_W-1:0] addr_inc;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] wdata;
  logic              last_field;
  logic              last_data;

  assign field_nxt  = {addr_q[ADDR_W-2:0], di_s};
  assign addr_inc   = addr_q + ADDR_W'(1);
  assign raddr      = (state_q == ST_FIELD) ? field_nxt : addr_inc;
  assign wdata      = {wr_sh_q[DATA_W-2:0], di_s};
  assign last_field = (cnt_q == CNT_W'(ADDR_W - 1));
  assign last_data  = (cnt_q == CNT_W'(DATA_W - 1));
  assign rd_active  = (state_q == ST_READ);

  assign mem_we = bit_stb && (state_q == ST_DATA) && last_data && wen_q && !busy;

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mem_we), .waddr_i(addr_q),
    .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata));

  mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(mem_we), .busy_o(busy));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      wr_sh_q <= '0;
      rd_sh_q <= '0;
      dout_q  <= 1'b0;
      wen_q   <= 1'b0;
      stat_q  <= 1'b0;
    end else if (!cs_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (bit_stb) begin
      unique case (state_q)
        ST_IDLE: if (di_s) begin
          state_q <= ST_OPC;
          cnt_q   <= '0;
          opc_q   <= '0;
          stat_q  <= 1'b0;
        end
        ST_OPC: begin
          opc_q <= {opc_q[0], di_s};
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_FIELD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIELD: begin
          addr_q <= field_nxt;
          if (last_field) begin
            cnt_q <= '0;
            unique case (opc_q)
              OPC_READ: begin
                state_q <= ST_READ;
                dout_q  <= 1'b0;            // dummy bit ahead of data
                rd_sh_q <= rdata;
              end
              OPC_WRITE: state_q <= ST_DATA;
              OPC_CTRL: begin
                state_q <= ST_DONE;
                if (field_nxt[ADDR_W-1 -: 2] == CTL_WEN)  wen_q <= 1'b1;
                if (field_nxt[ADDR_W-1 -: 2] == CTL_WDIS) wen_q <= 1'b0;
              end
              default: state_q <= ST_DONE;
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          wr_sh_q <= wdata;
          if (last_data) begin
            state_q <= ST_DONE;
            cnt_q   <= '0;
            if (mem_we) stat_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_READ: begin
          dout_q <= rd_sh_q[DATA_W-1];
          if (last_data) begin
            cnt_q   <= '0;
            addr_q  <= addr_inc;
            rd_sh_q <= rdata;               // next word, wraps at top
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            rd_sh_q <= {rd_sh_q[DATA_W-2:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

  logic drive;
  assign drive   = rd_active || ((state_q == ST_IDLE) && stat_q);
  assign do_en_o = cs_i && drive;
  assign do_o    = do_en_o && (rd_active ? dout_q : !busy);
endmodule

// File: rtl/mw_serial_mem_chk.sv
module mw_serial_mem_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic do_o,
  input logic do_en_o,
  input logic mem_we_i,
  input logic wen_i,
  input logic busy_i,
  input logic rd_active_i
);
  p_hiz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> !do_en_o);

  p_we_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> wen_i);

  p_we_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !busy_i);

  p_we_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> busy_i);

  p_dummy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_active_i) |-> !do_o);
endmodule

bind mw_serial_mem mw_serial_mem_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .do_o(do_o), .do_en_o(do_en_o),
  .mem_we_i(mem_we), .wen_i(wen_q), .busy_i(busy), .rd_active_i(rd_active));

// File: tb/tb_mw_serial_mem.sv
module tb_mw_serial_mem;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, den;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mw_serial_mem #(.PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(dout), .do_en_o(den));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic samp);
    sk = 1'b0; di = b;
    repeat (4) @(negedge clk);
    samp = dout;
    sk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic s;
    for (int i = n - 1; i >= 0; i--) bit_io(v[i], s);
  endtask

  task automatic cs_on();
    cs = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic cs_off();
    sk = 1'b0; repeat (2) @(negedge clk);
    cs = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    cs_on(); send({1'b1, 2'b01, a}, 9); send(d, 16); cs_off();
  endtask

  task automatic do_ctrl(input logic [1:0] f);
    cs_on(); send({1'b1, 2'b00, f, 4'b1010}, 9); cs_off();
  endtask

  task automatic rd_start(input logic [5:0] a, output logic dummy);
    cs_on(); send({1'b1, 2'b10, a}, 9); bit_io(1'b0, dummy);
  endtask

  task automatic rd_word(output logic [15:0] w);
    logic s;
    for (int i = 15; i >= 0; i--) begin bit_io(1'b0, s); w[i] = s; end
  endtask

  task automatic read1(input logic [5:0] a, output logic [15:0] w);
    logic dm;
    rd_start(a, dm); rd_word(w); cs_off();
  endtask

  // {is_write, addr, data}; reads compare with data
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 6'h00, 16'hA5A5}, {1'b1, 6'h3F, 16'h1234},
    {1'b1, 6'h15, 16'hFFFF}, {1'b1, 6'h2A, 16'h0001},
    {1'b0, 6'h00, 16'hA5A5}, {1'b0, 6'h3F, 16'h1234},
    {1'b0, 6'h2A, 16'h0001}, {1'b0, 6'h07, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic s, dm;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R10 do_en after reset", den, 1'b0);
    read1(6'h05, w); chk("R10 array zero", w, 16'h0);
    chk("R6 do_en with cs low", den, 1'b0);

    do_write(6'h09, 16'hBEEF); repeat (PROG + 20) @(negedge clk);
    read1(6'h09, w); chk("R5 write while disabled", w, 16'h0);

    do_ctrl(2'b11);
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][22]) begin
        do_write(VEC[i][21:16], VEC[i][15:0]);
        repeat (PROG + 20) @(negedge clk);
      end else begin
        read1(VEC[i][21:16], w);
        chk($sformatf("R2 R4 vec %0d", i), w, VEC[i][15:0]);
      end
    end

    // leading zeros before the start bit
    cs_on(); send(3'b000, 3);
    chk("R6 do_en during entry", den, 1'b0);
    send({1'b1, 2'b10, 6'h15}, 9);
    bit_io(1'b0, dm); chk("R2 dummy bit", dm, 1'b0);
    rd_word(w); chk("R1 read after zeros", w, 16'hFFFF);
    cs_off();

    // continued read wraps past the top
    rd_start(6'h3F, dm);
    rd_word(w); chk("R3 word 63", w, 16'h1234);
    rd_word(w); chk("R3 wrap to 0", w, 16'hA5A5);
    rd_word(w); chk("R3 word 1", w, 16'h0000);
    cs_off();

    // status flag
    do_write(6'h10, 16'h5A5A);
    cs = 1'b1; repeat (3) @(negedge clk);
    chk("R7 status driven", den, 1'b1);
    chk("R7 busy shown", dout, 1'b0);
    repeat (PROG + 20) @(negedge clk);
    chk("R7 ready shown", dout, 1'b1);
    bit_io(1'b1, s);
    chk("R7 cleared by start", den, 1'b0);
    cs_off();
    chk("R6 hiz after cs low", den, 1'b0);
    read1(6'h10, w); chk("R4 word 0x10", w, 16'h5A5A);

    // write during busy is dropped
    do_write(6'h11, 16'h1111);
    do_write(6'h12, 16'h2222);
    repeat (PROG + 20) @(negedge clk);
    read1(6'h12, w); chk("R9 busy write dropped", w, 16'h0);
    read1(6'h11, w); chk("R9 first write kept", w, 16'h1111);

    // aborted write
    cs_on(); send({1'b1, 2'b01, 6'h13}, 9); send(8'hC3, 8); cs_off();
    repeat (PROG + 20) @(negedge clk);
    read1(6'h13, w); chk("R8 aborted write", w, 16'h0);

    // disable again
    do_ctrl(2'b00);
    do_write(6'h14, 16'h7777); repeat (PROG + 20) @(negedge clk);
    read1(6'h14, w); chk("R5 disabled again", w, 16'h0);
    cs = 1'b1; repeat (3) @(negedge clk);
    chk("R7 no status after drop", den, 1'b0);
    cs = 1'b0; repeat (4) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule